// File: doc/BRIEF.md
# Burst WAIT Handshake Generator

This block sits on the device side of a synchronous burst memory and drives the WAIT handshake pin during READ and WRITE bursts. The controller opens a burst with a one-cycle start strobe and closes it with a one-cycle end strobe. Inside the burst, the array timing logic reports through a per-cycle ready bit whether the beat for that cycle can be moved. From these inputs the block produces two outputs: WAIT, which tells the controller to hold off, and a data-valid strobe that times the data-bus output enable.

A write port for the bus configuration word supplies three settings. The WAIT-lead bit chooses whether WAIT changes one clock ahead of data-valid or on the same edge as it. The polarity bit chooses whether an asserted WAIT is driven high or low. The two-bit drive-strength field is only held in a register and passed out to the pad control. There is no streaming payload at this boundary: every pin is a plain control or status level.

Top module: `burst_wait_gen`

## Requirements
- R1: After reset the WAIT-lead bit is 1, the polarity bit is 1 (asserted WAIT is high), drive-strength reads 2'b01, `wait_o` is low and `data_valid` is low.
- R2: When `cfg_we` is high, bit 8 of `cfg_wdata` is loaded as the WAIT-lead bit, bit 10 as the polarity bit, and bits 5:4 as the drive-strength code (00 full, 01 half, 10 quarter). All three take effect from the next clock edge. All other bits are ignored.
- R3: A configuration write whose bits 5:4 are 2'b11 (the reserved code) leaves the drive-strength output unchanged.
- R4: A cycle is inside a burst when `burst_start` is high, or when a burst is open and `burst_end` is low. The cycle with `burst_end` high is outside the burst. `beat_rdy` in a cycle outside a burst has no effect on either output.
- R5: `data_valid` is high exactly two clock edges after a cycle that is inside a burst and has `beat_rdy` high.
- R6: With the WAIT-lead bit at 1, WAIT is asserted exactly one edge after a cycle that is inside a burst and has `beat_rdy` low. Each WAIT transition therefore comes one cycle before the matching `data_valid` transition.
- R7: With the WAIT-lead bit at 0, WAIT is asserted exactly two edges after such a cycle. WAIT deassertion then coincides with `data_valid` rising, and WAIT assertion coincides with `data_valid` falling.
- R8: With the polarity bit at 0, `wait_o` is the inverse of its active-high value in both timing modes.
- R9: When no burst cycle is still in flight in the pipeline, `wait_o` is at the deasserted level for the current polarity and `data_valid` is low.
- R10: A not-ready cycle in the middle of a burst reasserts WAIT for that beat, with the same lead or alignment as at the start of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word (bit 8 lead, bit 10 polarity, bits 5:4 drive) |
| burst_start | input | 1 | One-cycle burst open strobe |
| burst_end | input | 1 | One-cycle burst close strobe |
| beat_rdy | input | 1 | Array can move this cycle's beat |
| wait_o | output | 1 | WAIT handshake pin level |
| data_valid | output | 1 | Data bus valid / output-enable timing |
| drive_o | output | 2 | Stored drive-strength code |

## Verification
On every cycle the assertions check the cycle offset between WAIT and data-valid in each timing mode. They also check that both outputs are quiet when nothing is in flight, that a reserved drive code never alters the stored field, and that data-valid never appears without an earlier burst cycle. Other behaviour can only be shown by the bench's scenarios: the exact latency from a ready or not-ready cycle to the outputs, the reset values, the decoding of the configuration bits, the inverted polarity, and the reassertion of WAIT at a mid-burst stall. The bench compares every cycle against a model built from the requirements, under random bursts in all four mode and polarity combinations.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  localparam int unsigned CFG_W    = 16;
  localparam int unsigned LEAD_BIT = 8;
  localparam int unsigned POL_BIT  = 10;
  localparam int unsigned DRV_LSB  = 4;
  localparam int unsigned DRV_W    = 2;

  typedef enum logic [DRV_W-1:0] {
    DRV_FULL    = 2'b00,
    DRV_HALF    = 2'b01,
    DRV_QUARTER = 2'b10,
    DRV_RSVD    = 2'b11
  } drv_e;

  typedef struct packed {
    logic lead;
    logic act_high;
    drv_e drv;
  } bus_cfg_t;

  localparam bus_cfg_t CFG_RESET = '{lead: 1'b1, act_high: 1'b1, drv: DRV_HALF};
endpackage

// File: rtl/bwg_cfg_reg.sv
module bwg_cfg_reg
  import bwg_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output bus_cfg_t     cfg
);
  drv_e drv_req;
  logic unused_bits;

  assign drv_req     = drv_e'(wdata[DRV_LSB +: DRV_W]);
  assign unused_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else if (we) begin
      cfg.lead     <= wdata[LEAD_BIT];
      cfg.act_high <= wdata[POL_BIT];
      // reserved drive code leaves the field as it was
      if (drv_req != DRV_RSVD) cfg.drv <= drv_req;
    end
  end
endmodule

// File: rtl/bwg_beat_pipe.sv
module bwg_beat_pipe #(
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_start,
  input  logic             burst_end,
  input  logic             beat_rdy,
  output logic [DEPTH-1:0] act_tap,
  output logic [DEPTH-1:0] rdy_tap
);
  logic busy;
  logic in_burst;

  assign in_burst = burst_start | (busy & ~burst_end);

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= in_burst;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          act_tap[0] <= 1'b0;
          rdy_tap[0] <= 1'b0;
        end else begin
          act_tap[0] <= in_burst;
          rdy_tap[0] <= in_burst & beat_rdy;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          act_tap[g] <= 1'b0;
          rdy_tap[g] <= 1'b0;
        end else begin
          act_tap[g] <= act_tap[g-1];
          rdy_tap[g] <= rdy_tap[g-1];
        end
      end
    end
  end
endmodule

// File: rtl/bwg_wait_drive.sv
module bwg_wait_drive #(
  parameter int unsigned DEPTH = 2
) (
  input  logic             lead,
  input  logic             act_high,
  input  logic [DEPTH-1:0] act_tap,
  input  logic [DEPTH-1:0] rdy_tap,
  output logic             wait_o,
  output logic             data_valid
);
  localparam int unsigned LAST_TAP = DEPTH - 1;
  localparam int unsigned LEAD_TAP = DEPTH - 2;

  logic hold_early;
  logic hold_late;
  logic hold;

  assign hold_early = act_tap[LEAD_TAP] & ~rdy_tap[LEAD_TAP];
  assign hold_late  = act_tap[LAST_TAP] & ~rdy_tap[LAST_TAP];
  assign hold       = lead ? hold_early : hold_late;
  assign wait_o     = act_high ? hold : ~hold;
  assign data_valid = rdy_tap[LAST_TAP];
endmodule

// File: rtl/burst_wait_gen.sv
module burst_wait_gen
  import bwg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             burst_start,
  input  logic             burst_end,
  input  logic             beat_rdy,
  output logic             wait_o,
  output logic             data_valid,
  output logic [DRV_W-1:0] drive_o
);
  localparam int unsigned PIPE_DEPTH = 2;

  bus_cfg_t              cfg_q;
  logic [PIPE_DEPTH-1:0] act_tap;
  logic [PIPE_DEPTH-1:0] rdy_tap;

  bwg_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg_q)
  );

  bwg_beat_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_start (burst_start),
    .burst_end   (burst_end),
    .beat_rdy    (beat_rdy),
    .act_tap     (act_tap),
    .rdy_tap     (rdy_tap)
  );

  bwg_wait_drive #(.DEPTH(PIPE_DEPTH)) u_drive (
    .lead       (cfg_q.lead),
    .act_high   (cfg_q.act_high),
    .act_tap    (act_tap),
    .rdy_tap    (rdy_tap),
    .wait_o     (wait_o),
    .data_valid (data_valid)
  );

  assign drive_o = cfg_q.drv;
endmodule

// File: rtl/bwg_chk.sv
module bwg_chk #(
  parameter int unsigned DEPTH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       wr_drv,
  input logic             lead,
  input logic             act_high,
  input logic [DEPTH-1:0] act_tap,
  input logic             wait_o,
  input logic             data_valid,
  input logic [1:0]       drive_o
);
  localparam int unsigned LAST_TAP = DEPTH - 1;

  logic wait_asrt;
  assign wait_asrt = (wait_o == act_high);

  // R6
  lead_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lead && $past(lead) && (act_high == $past(act_high)) && $past(act_tap[0]))
      |-> (data_valid == !$past(wait_asrt)));

  // R7
  aligned_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lead && act_tap[LAST_TAP]) |-> (data_valid == !wait_asrt));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_tap == '0) |-> (!wait_asrt && !data_valid));

  // R3
  rsvd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_drv == 2'b11) |=> $stable(drive_o));

  // R4
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(act_tap[0]));
endmodule

bind burst_wait_gen bwg_chk #(.DEPTH(PIPE_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .wr_drv     (cfg_wdata[bwg_pkg::DRV_LSB +: 2]),
  .lead       (cfg_q.lead),
  .act_high   (cfg_q.act_high),
  .act_tap    (act_tap),
  .wait_o     (wait_o),
  .data_valid (data_valid),
  .drive_o    (drive_o)
);

// File: tb/burst_wait_gen_bench.sv
module burst_wait_gen_bench;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        burst_start = 1'b0;
  logic        burst_end = 1'b0;
  logic        beat_rdy = 1'b0;
  logic        wait_o;
  logic        data_valid;
  logic [1:0]  drive_o;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          done = 1'b0;

  // model state, built from the requirements
  logic       m_busy = 0, p1_ib = 0, p1_r = 0, p2_ib = 0, p2_r = 0;
  logic       m_lead = 1, m_pol = 1;
  logic [1:0] m_drv = 2'b01;
  string      ctx = "";

  burst_wait_gen u_burst_wait_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .burst_start(burst_start), .burst_end(burst_end), .beat_rdy(beat_rdy),
    .wait_o(wait_o), .data_valid(data_valid), .drive_o(drive_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %b expected %b", tag, ctx, got, exp);
    end
  endtask

  function automatic logic [15:0] cfg_word(input logic lead, input logic pol, input logic [1:0] drv);
    logic [15:0] w;
    w = 16'($urandom);
    w[8] = lead;
    w[10] = pol;
    w[5:4] = drv;
    return w;
  endfunction

  // called at a falling edge: check outputs, drive next inputs, advance one cycle
  task automatic step(input logic st, input logic en, input logic rdy,
                      input logic we = 1'b0, input logic [15:0] wd = '0);
    logic  hold, ib;
    string wtag;
    hold = m_lead ? (p1_ib & ~p1_r) : (p2_ib & ~p2_r);
    if (!(p1_ib | p2_ib))  wtag = "R9";
    else if (m_lead)       wtag = m_pol ? "R6" : "R6 R8";
    else                   wtag = m_pol ? "R7" : "R7 R8";
    chk("R5 data_valid", {1'b0, data_valid}, {1'b0, p2_ib & p2_r});
    chk({wtag, " wait_o"}, {1'b0, wait_o}, {1'b0, m_pol ? hold : ~hold});
    chk("R2 drive_o", drive_o, m_drv);
    burst_start = st; burst_end = en; beat_rdy = rdy; cfg_we = we; cfg_wdata = wd;
    ib = st | (m_busy & ~en);
    m_busy = ib;
    p2_ib = p1_ib; p2_r = p1_r;
    p1_ib = ib;    p1_r = rdy;
    if (we) begin
      m_lead = wd[8];
      m_pol  = wd[10];
      if (wd[5:4] != 2'b11) m_drv = wd[5:4];
    end
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic lead, input logic pol, input logic [1:0] drv);
    step(0, 0, 1'($urandom), 1'b1, cfg_word(lead, pol, drv));
    step(0, 0, 0);
  endtask

  task automatic rand_burst();
    int unsigned len;
    len = 1 + ($urandom % 12);
    ctx = "";
    step(1, 0, ($urandom % 10) < 4);
    for (int i = 0; i < int'(len); i++) step(0, 0, ($urandom % 10) < 7);
    step(0, 1, 1'($urandom));
    ctx = "R4 idle";
    for (int i = 0; i < 3; i++) step(0, 0, 1'($urandom));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    ctx = "R1 reset";
    chk("R1 wait_o", {1'b0, wait_o}, 2'b00);
    chk("R1 data_valid", {1'b0, data_valid}, 2'b00);
    chk("R1 drive_o", drive_o, 2'b01);
    step(0, 0, 0);
    // R1 default lead mode: start with not-ready then ready
    ctx = "R1 default lead";
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 1); step(0, 0, 1); step(0, 1, 0);
    step(0, 0, 0); step(0, 0, 0);

    // R2 drive decode, R3 reserved code ignored
    ctx = "R2 drive write";
    set_cfg(1, 1, 2'b10);
    chk("R2 drive quarter", drive_o, 2'b10);
    ctx = "R3 reserved";
    set_cfg(1, 1, 2'b11);
    chk("R3 drive kept", drive_o, 2'b10);
    set_cfg(1, 1, 2'b00);

    // R4 ready outside any burst has no effect
    ctx = "R4 idle ready";
    for (int i = 0; i < 4; i++) step(0, 0, 1);

    // R10 mid-burst stall in each mode and polarity
    for (int c = 0; c < 4; c++) begin
      set_cfg(c[0], c[1], 2'b01);
      ctx = "R10 stall";
      step(1, 0, 1); step(0, 0, 1); step(0, 0, 0); step(0, 0, 0);
      step(0, 0, 1); step(0, 0, 1); step(0, 1, 0);
      step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    end

    // random bursts across all four settings
    for (int c = 0; c < 4; c++) begin
      set_cfg(c[1], c[0], 2'($urandom % 3));
      for (int b = 0; b < 40; b++) rand_burst();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule